// File: doc/BRIEF.md
# Iterative XOR-AND Carry Adder

A sequential 4-bit adder that finds a sum by repeating a carry-free step until no carry is left. Two operands are taken on a start pulse: the first goes into an accumulator register, the second into a carry register.

On every following clock the accumulator is replaced by the bitwise XOR of the two registers. The carry register is replaced by their bitwise AND shifted left by one place. The bit shifted out of the top is collected into a sticky overflow flag. The loop stops as soon as the carry register holds zero, so the cycle count depends on how far carries travel in the data.

A caller pulses `start_i` while `busy_o` is low and waits for the one-cycle `done_o` pulse. It then reads the 4-bit sum, the overflow bit and the number of iterations used. The full result is the overflow bit weighted by 16 plus the 4-bit sum.

Top module: `carry_loop_adder`

## Requirements
- R1: While reset is asserted and just after it is released, `busy_o`, `done_o`, `ovf_o`, `sum_o` and `steps_o` are all zero.
- R2: A start pulse seen while idle loads the operands on that clock edge. In the next cycle `busy_o` is 1, `sum_o` equals operand A, `steps_o` is 0 and `ovf_o` is 0, even if the previous result had overflowed.
- R3: When `done_o` is high, `ovf_o`*16 + `sum_o` equals A + B, so `sum_o` is (A+B) mod 16 and `ovf_o` is 1 exactly when A+B ≥ 16.
- R4: During a run, once `ovf_o` is 1 it stays 1 until the next accepted start.
- R5: Iterations run only while the carry register is non-zero, and `steps_o` never exceeds 4. Operands 9 and 6 need exactly 1 iteration. Operands 15 and 1 need exactly 4 and overflow.
- R6: If operand B is 0, the run completes after 0 iterations with `sum_o` = A and `ovf_o` = 0.
- R7: `done_o` is a single-cycle pulse. It rises on the (k+1)-th clock edge after the edge that accepted start, where k is the final `steps_o`, and `busy_o` is low in that same cycle.
- R8: A start pulse that arrives while `busy_o` is high is ignored: the running addition finishes with its own operands.
- R9: After `done_o`, `sum_o`, `ovf_o` and `steps_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| op_a_i | input | 4 | Operand A, loaded into the accumulator |
| op_b_i | input | 4 | Operand B, loaded into the carry register |
| busy_o | output | 1 | High while iterating |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 4 | Accumulator, the sum modulo 16 when done |
| ovf_o | output | 1 | Sticky overflow, the 16s place of the sum |
| steps_o | output | 3 | Number of iterations used |

## Verification
The assertions check the following on every cycle:
- the sum identity against operands captured at start;
- the sticky overflow flag;
- the iteration bound;
- the single-cycle done pulse;
- the load state after a start;
- that a start while busy leaves the counter advancing monotonically;
- that the outputs hold while idle.

Only the bench's scenarios can show some behaviours. These are the exact iteration counts for the chosen operand pairs, the done latency measured against `steps_o` over all 256 operand pairs, and the overflow clear on a reload after an overflowing run. They also include a start injected mid-run with different operands leaving the original result intact.

// File: rtl/carry_loop_pkg.sv
package carry_loop_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } loop_state_e;
endpackage

// File: rtl/carry_loop_step.sv
// One carry-free iteration: XOR sum plus shifted AND carry.
module carry_loop_step #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] carry_o,
  output logic             cout_o
);
  logic [WIDTH:0] gen_sh;

  assign gen_sh[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign acc_o[i]     = acc_i[i] ^ carry_i[i];
    assign gen_sh[i+1]  = acc_i[i] & carry_i[i];
  end

  assign carry_o = gen_sh[WIDTH-1:0];
  assign cout_o  = gen_sh[WIDTH];
endmodule

// File: rtl/carry_loop_ctrl.sv
module carry_loop_ctrl
  import carry_loop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic carry_zero_i,
  output logic load_o,
  output logic iter_o,
  output logic busy_o,
  output logic done_o
);
  loop_state_e state_q, state_d;
  logic        done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (carry_zero_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RUN) && carry_zero_i;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign iter_o = (state_q == ST_RUN) && !carry_zero_i;
  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/carry_loop_count.sv
module carry_loop_count #(
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [STEP_W-1:0] cnt_o
);
  localparam logic [STEP_W-1:0] ONE = {{(STEP_W-1){1'b0}}, 1'b1};
  logic [STEP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/carry_loop_adder.sv
module carry_loop_adder #(
  parameter int WIDTH  = 4,
  parameter int STEP_W = $clog2(WIDTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIDTH-1:0]  op_a_i,
  input  logic [WIDTH-1:0]  op_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WIDTH-1:0]  sum_o,
  output logic              ovf_o,
  output logic [STEP_W-1:0] steps_o
);
  logic [WIDTH-1:0] acc_q, carry_q, acc_nxt, carry_nxt;
  logic             ovf_q, cout;
  logic             load, iter, carry_zero;

  assign carry_zero = (carry_q == '0);

  carry_loop_step #(.WIDTH(WIDTH)) step_i (
    .acc_i   (acc_q),
    .carry_i (carry_q),
    .acc_o   (acc_nxt),
    .carry_o (carry_nxt),
    .cout_o  (cout)
  );

  carry_loop_ctrl ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .carry_zero_i (carry_zero),
    .load_o       (load),
    .iter_o       (iter),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  carry_loop_count #(.STEP_W(STEP_W)) count_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .inc_i  (iter),
    .cnt_o  (steps_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= '0;
      ovf_q   <= 1'b0;
    end else if (load) begin
      acc_q   <= op_a_i;
      carry_q <= op_b_i;
      ovf_q   <= 1'b0;
    end else if (iter) begin
      acc_q   <= acc_nxt;
      carry_q <= carry_nxt;
      ovf_q   <= ovf_q | cout;   // sticky
    end
  end

  assign sum_o = acc_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/carry_loop_adder_chk.sv
module carry_loop_adder_chk #(
  parameter int WIDTH  = 4,
  parameter int STEP_W = $clog2(WIDTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [WIDTH-1:0]  op_a_i,
  input logic [WIDTH-1:0]  op_b_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [WIDTH-1:0]  sum_o,
  input logic              ovf_o,
  input logic [STEP_W-1:0] steps_o
);
  localparam logic [STEP_W-1:0] MAX_STEPS = STEP_W'(WIDTH);
  logic [WIDTH-1:0] cap_a, cap_b;
  logic             accept;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (accept) begin
      cap_a <= op_a_i;
      cap_b <= op_b_i;
    end
  end

  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!busy_o && !done_o && !ovf_o && sum_o == '0 && steps_o == '0);
    end
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o && !ovf_o && steps_o == '0 && sum_o == $past(op_a_i));

  p_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> {ovf_o, sum_o} == ({1'b0, cap_a} + {1'b0, cap_b}));

  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !accept) |=> ovf_o);

  p_step_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_o <= MAX_STEPS);

  p_zero_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_b == '0) |-> steps_o == '0 && sum_o == cap_a && !ovf_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_busy_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> steps_o == $past(steps_o) || steps_o == $past(steps_o) + 1'b1);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(sum_o) && $stable(ovf_o) && $stable(steps_o));
endmodule

bind carry_loop_adder carry_loop_adder_chk #(.WIDTH(WIDTH), .STEP_W(STEP_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_a_i  (op_a_i),
  .op_b_i  (op_b_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sum_o   (sum_o),
  .ovf_o   (ovf_o),
  .steps_o (steps_o)
);

// File: tb/carry_loop_adder_tb_top.sv
module carry_loop_adder_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] op_a_i = '0, op_b_i = '0;
  logic       busy_o, done_o, ovf_o;
  logic [3:0] sum_o;
  logic [2:0] steps_o;

  int total = 0;
  int bad = 0;
  int max_steps = 0;

  always #2 clk_i = ~clk_i;

  carry_loop_adder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i),
    .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o),
    .ovf_o(ovf_o), .steps_o(steps_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one addition; optional disturbing start on the 2nd busy cycle.
  task automatic run_add(input int a, input int b, input bit disturb,
                         output int cycles);
    @(negedge clk_i);
    start_i = 1'b1; op_a_i = 4'(a); op_b_i = 4'(b);
    @(negedge clk_i);
    start_i = 1'b0;
    cycles = 1;
    check("R2 busy after start", int'(busy_o), 1);
    check("R2 sum loaded", int'(sum_o), a);
    check("R2 steps cleared", int'(steps_o), 0);
    check("R2 ovf cleared", int'(ovf_o), 0);
    if (disturb) begin
      start_i = 1'b1; op_a_i = 4'd0; op_b_i = 4'd0;
    end
    while (!done_o && cycles < 20) begin
      @(negedge clk_i);
      start_i = 1'b0;
      cycles++;
    end
    check("R7 done arrives", int'(done_o), 1);
    check("R7 done with busy low", int'(busy_o), 0);
    check("R7 latency vs steps", cycles, int'(steps_o) + 2);
    check("R3 sum mod 16", int'(sum_o), (a + b) % 16);
    check("R3 overflow", int'(ovf_o), (a + b) >= 16 ? 1 : 0);
    check("R5 step bound", int'(steps_o <= 3'd4), 1);
    if (int'(steps_o) > max_steps) max_steps = int'(steps_o);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int cyc;
    int s0, o0, t0;
    repeat (3) @(negedge clk_i);
    check("R1 busy in reset", int'(busy_o), 0);
    check("R1 sum in reset", int'(sum_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 busy after reset", int'(busy_o), 0);
    check("R1 done after reset", int'(done_o), 0);
    check("R1 ovf after reset", int'(ovf_o), 0);
    check("R1 steps after reset", int'(steps_o), 0);

    run_add(9, 6, 1'b0, cyc);
    check("R5 9+6 steps", int'(steps_o), 1);

    run_add(15, 1, 1'b0, cyc);
    check("R5 15+1 steps", int'(steps_o), 4);
    check("R5 15+1 ovf", int'(ovf_o), 1);
    // reload after overflow: run_add checks ovf cleared (R2)
    run_add(15, 1, 1'b0, cyc);

    run_add(11, 0, 1'b0, cyc);
    check("R6 zero b steps", int'(steps_o), 0);
    check("R6 zero b sum", int'(sum_o), 11);
    check("R6 zero b ovf", int'(ovf_o), 0);

    // R8: start while busy must not replace operands
    run_add(15, 1, 1'b1, cyc);
    check("R8 ignored start steps", int'(steps_o), 4);

    // R7 pulse width and R9 hold
    s0 = int'(sum_o); o0 = int'(ovf_o); t0 = int'(steps_o);
    @(negedge clk_i);
    check("R7 done single cycle", int'(done_o), 0);
    repeat (3) @(negedge clk_i);
    check("R9 sum holds", int'(sum_o), s0);
    check("R9 ovf holds", int'(ovf_o), o0);
    check("R9 steps holds", int'(steps_o), t0);

    // Exhaustive sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_add(a, b, 1'b0, cyc);
      end
    end
    check("R5 max steps over sweep", max_steps, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule